// File: doc/BRIEF.md
# Memory region lock and bus-error monitor

This block guards the memory bus of a small processor. Software may seal up to ten address windows against writes. No single write seals a window. Each window has a guard register, shared by two windows. The window is sealed after two writes to that register in a row: the first carries an arming key in the window's half, and the second carries a committing key in the same half. Once a window is sealed, any write the bus presents inside it is blocked in the same cycle. It is also recorded as a protection fault.

The block also records accesses that a bus slave rejects, and timeouts reported by an external watchdog. The first protection or slave fault has its address captured in two forms. One is the raw bus address. The other is split by memory space: a data-memory field and a program-memory field. The captures hold until software acknowledges. An interrupt stays asserted while any fault flag is set. An optional pause request asks the core to halt while the interrupt is pending.

Top module: `region_guard`

## Requirements
- R1: After reset all fault flags, captures, the interrupt, the pause request and the pause enable are zero, and no window is sealed, so no write is blocked.
- R2: Window 2k+h is sealed by two consecutive writes to the guard register at word offset 2k (k = 0..4). Bits 15:0 (h=0) or bits 31:16 (h=1) must hold 16'h5555 in the first write and 16'hAAAA in the second.
- R3: If a half is armed and the next write to its register does not carry 16'hAAAA in that half, the arming is dropped. A later lone 16'hAAAA write does not seal the window.
- R4: A single pair of writes carrying 32'h55555555 and then 32'hAAAAAAAA seals both windows of that register.
- R5: Writes to other register offsets between the two key writes neither drop nor complete the arming.
- R6: Window i covers bus addresses 0x1000 + i*0x100 through 0x1000 + i*0x100 + 0x3F. While the window is sealed, a write there (bus_valid and bus_write high) drives wr_block high in that same cycle. Reads, unsealed windows and addresses outside every window are never blocked.
- R7: A blocked write sets status bit 15 of the control/status register (offset 0x10). A slave-rejected access sets bit 14, and a high wdt_timeout sets bit 13. Each flag is visible from the cycle after the event.
- R8: The first protection or slave fault captures its address. Offset 0x11 reads the bus address in bits 23:0. Offset 0x12 reads addr[15:0] in bits 15:0 for a data-space access (bus_space=0), or addr[14:0] in bits 30:16 for a program-space access (bus_space=1), with all other bits zero. Later faults do not overwrite the capture until acknowledge.
- R9: irq is high exactly while any of the three flags is set. Writing 0x10 with bit 0 set clears all flags and both captures.
- R10: Bit 1 of offset 0x10 is a read/write pause enable. pause_req equals pause enable AND irq.
- R11: A sealed window stays sealed until reset, across acknowledges and any further key writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 5 | Register word offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational from reg_addr) |
| bus_valid | input | 1 | Memory bus access present |
| bus_write | input | 1 | Access is a write |
| bus_space | input | 1 | 0 = data memory, 1 = program memory |
| bus_addr | input | 24 | Access address |
| bus_slave_err | input | 1 | Slave rejected the access |
| wr_block | output | 1 | Current write hits a sealed window and is suppressed |
| wdt_timeout | input | 1 | Timeout from external watchdog counter |
| irq | output | 1 | Fault interrupt |
| pause_req | output | 1 | Request to halt the core while a fault is pending |

## Verification
Every cycle, the bound checker confirms that each fault event raises its own flag one cycle later. It also checks that a pending capture stays frozen until acknowledge, that an acknowledge with no new event drops the interrupt, that pause_req never appears without irq, that sealed windows never unseal, and that nothing is blocked while no window is sealed. The key sequences themselves can only be shown by the bench's scenarios, because whether a window becomes sealed depends on a history of register writes. This covers arming, abandoning, interleaving other writes, and sealing both halves at once. Address decoding at every window's edges is also shown by the bench, as are the data- and program-space split of the capture and the exact register read values.

// File: rtl/rg_pkg.sv
package rg_pkg;
  localparam logic [15:0] KEY_ARM    = 16'h5555;
  localparam logic [15:0] KEY_COMMIT = 16'hAAAA;

  localparam int CTRL_ADDR   = 16;
  localparam int BUSERR_ADDR = 17;
  localparam int MEMERR_ADDR = 18;

  localparam int ST_LOCK_BIT  = 15;
  localparam int ST_SLAVE_BIT = 14;
  localparam int ST_WDT_BIT   = 13;
  localparam int CT_PAUSE_BIT = 1;
  localparam int CT_ACK_BIT   = 0;

  typedef enum logic [1:0] {KS_IDLE, KS_ARMED, KS_SEALED} key_state_e;

  function automatic logic [31:0] window_lo(int unsigned base, int unsigned stride, int idx);
    return 32'(base) + 32'(idx) * 32'(stride);
  endfunction

  function automatic logic in_window(logic [31:0] a, logic [31:0] lo, int unsigned size);
    return (a >= lo) && ((a - lo) < 32'(size));
  endfunction

  function automatic logic [31:0] split_mem_addr(logic space, logic [31:0] a);
    return space ? {1'b0, a[14:0], 16'h0000} : {16'h0000, a[15:0]};
  endfunction
endpackage

// File: rtl/rg_key_lock.sv
module rg_key_lock
  import rg_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_hit,
  input  logic [31:0] wdata,
  output logic [1:0]  sealed
);
  for (genvar h = 0; h < 2; h++) begin : g_half
    key_state_e  st;
    logic [15:0] key;
    assign key = wdata[16*h +: 16];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        st <= KS_IDLE;
      end else if (wr_hit) begin
        case (st)
          KS_IDLE:  if (key == KEY_ARM) st <= KS_ARMED;
          KS_ARMED: st <= (key == KEY_COMMIT) ? KS_SEALED : KS_IDLE;
          default:  st <= st;
        endcase
      end
    end

    assign sealed[h] = (st == KS_SEALED);
  end
endmodule

// File: rtl/rg_region_match.sv
module rg_region_match
  import rg_pkg::*;
#(
  parameter int          NUM_REGIONS   = 10,
  parameter int          ADDR_W        = 24,
  parameter int unsigned REGION_BASE   = 32'h1000,
  parameter int unsigned REGION_STRIDE = 32'h100,
  parameter int unsigned REGION_SIZE   = 32'h40
) (
  input  logic [ADDR_W-1:0]      addr,
  input  logic [NUM_REGIONS-1:0] sealed,
  output logic [NUM_REGIONS-1:0] in_win,
  output logic                   hit_sealed
);
  logic [31:0] addr32;
  assign addr32 = 32'(addr);

  for (genvar i = 0; i < NUM_REGIONS; i++) begin : g_win
    assign in_win[i] = in_window(addr32, window_lo(REGION_BASE, REGION_STRIDE, i), REGION_SIZE);
  end

  assign hit_sealed = |(in_win & sealed);
endmodule

// File: rtl/rg_fault_log.sv
module rg_fault_log
  import rg_pkg::*;
#(
  parameter int ADDR_W = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lock_evt,
  input  logic              slave_evt,
  input  logic              wdt_evt,
  input  logic              ack,
  input  logic [ADDR_W-1:0] fault_addr,
  input  logic              fault_space,
  output logic [2:0]        status_q,
  output logic [23:0]       bus_err_q,
  output logic [31:0]       mem_err_q
);
  logic cap_busy;
  logic cap_take;

  assign cap_busy = (status_q[2] | status_q[1]) & ~ack;
  assign cap_take = (lock_evt | slave_evt) & ~cap_busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status_q  <= '0;
      bus_err_q <= '0;
      mem_err_q <= '0;
    end else begin
      status_q <= (status_q & {3{~ack}}) | {lock_evt, slave_evt, wdt_evt};
      if (cap_take) begin
        bus_err_q <= 24'(32'(fault_addr));
        mem_err_q <= split_mem_addr(fault_space, 32'(fault_addr));
      end else if (ack) begin
        bus_err_q <= '0;
        mem_err_q <= '0;
      end
    end
  end
endmodule

// File: rtl/region_guard.sv
module region_guard
  import rg_pkg::*;
#(
  parameter int          NUM_REGIONS   = 10,
  parameter int          ADDR_W        = 24,
  parameter int          REG_AW        = 5,
  parameter int unsigned REGION_BASE   = 32'h1000,
  parameter int unsigned REGION_STRIDE = 32'h100,
  parameter int unsigned REGION_SIZE   = 32'h40
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  logic              bus_valid,
  input  logic              bus_write,
  input  logic              bus_space,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_slave_err,
  output logic              wr_block,
  input  logic              wdt_timeout,
  output logic              irq,
  output logic              pause_req
);
  localparam int NUM_PAIRS = NUM_REGIONS / 2;

  logic [NUM_REGIONS-1:0] sealed;
  logic [NUM_REGIONS-1:0] in_win;
  logic [NUM_PAIRS-1:0]   pair_wr;
  logic                   hit_sealed;
  logic                   violation;
  logic                   slave_evt;
  logic                   ctrl_wr;
  logic                   ack_wr;
  logic                   pause_en;
  logic [2:0]             status_q;
  logic [23:0]            bus_err_q;
  logic [31:0]            mem_err_q;

  for (genvar p = 0; p < NUM_PAIRS; p++) begin : g_pair
    assign pair_wr[p] = reg_wr && (reg_addr == REG_AW'(2 * p));
    rg_key_lock u_key (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_hit (pair_wr[p]),
      .wdata  (reg_wdata),
      .sealed (sealed[2*p +: 2])
    );
  end

  rg_region_match #(
    .NUM_REGIONS   (NUM_REGIONS),
    .ADDR_W        (ADDR_W),
    .REGION_BASE   (REGION_BASE),
    .REGION_STRIDE (REGION_STRIDE),
    .REGION_SIZE   (REGION_SIZE)
  ) u_match (
    .addr       (bus_addr),
    .sealed     (sealed),
    .in_win     (in_win),
    .hit_sealed (hit_sealed)
  );

  assign violation = bus_valid && bus_write && hit_sealed;
  assign slave_evt = bus_valid && bus_slave_err;
  assign wr_block  = violation;

  assign ctrl_wr = reg_wr && (reg_addr == REG_AW'(CTRL_ADDR));
  assign ack_wr  = ctrl_wr && reg_wdata[CT_ACK_BIT];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       pause_en <= 1'b0;
    else if (ctrl_wr) pause_en <= reg_wdata[CT_PAUSE_BIT];
  end

  rg_fault_log #(.ADDR_W(ADDR_W)) u_log (
    .clk         (clk),
    .rst_n       (rst_n),
    .lock_evt    (violation),
    .slave_evt   (slave_evt),
    .wdt_evt     (wdt_timeout),
    .ack         (ack_wr),
    .fault_addr  (bus_addr),
    .fault_space (bus_space),
    .status_q    (status_q),
    .bus_err_q   (bus_err_q),
    .mem_err_q   (mem_err_q)
  );

  assign irq       = |status_q;
  assign pause_req = pause_en && irq;

  always_comb begin
    reg_rdata = '0;
    if (reg_addr == REG_AW'(CTRL_ADDR)) begin
      reg_rdata[ST_LOCK_BIT]  = status_q[2];
      reg_rdata[ST_SLAVE_BIT] = status_q[1];
      reg_rdata[ST_WDT_BIT]   = status_q[0];
      reg_rdata[CT_PAUSE_BIT] = pause_en;
    end else if (reg_addr == REG_AW'(BUSERR_ADDR)) begin
      reg_rdata = {8'h00, bus_err_q};
    end else if (reg_addr == REG_AW'(MEMERR_ADDR)) begin
      reg_rdata = mem_err_q;
    end
  end
endmodule

// File: rtl/rg_checker.sv
module rg_checker #(
  parameter int NUM_REGIONS = 10
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   bus_valid,
  input logic                   bus_slave_err,
  input logic                   wdt_timeout,
  input logic                   wr_block,
  input logic                   irq,
  input logic                   pause_req,
  input logic                   violation,
  input logic                   ack_wr,
  input logic [2:0]             status_q,
  input logic [23:0]            bus_err_q,
  input logic [NUM_REGIONS-1:0] sealed
);
  a_r2_no_block_when_open: assert property (@(posedge clk) disable iff (!rst_n)
    (sealed == '0) |-> !wr_block);

  a_r7_lock_flag: assert property (@(posedge clk) disable iff (!rst_n)
    violation |=> status_q[2]);

  a_r7_slave_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && bus_slave_err) |=> status_q[1]);

  a_r7_wdt_flag: assert property (@(posedge clk) disable iff (!rst_n)
    wdt_timeout |=> status_q[0]);

  a_r8_capture_hold: assert property (@(posedge clk) disable iff (!rst_n)
    ((status_q[2] || status_q[1]) && !ack_wr) |=> $stable(bus_err_q));

  a_r9_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_wr && !violation && !(bus_valid && bus_slave_err) && !wdt_timeout) |=> !irq);

  a_r10_pause_needs_irq: assert property (@(posedge clk) disable iff (!rst_n)
    pause_req |-> irq);

  a_r11_seal_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((sealed & $past(sealed)) == $past(sealed)));
endmodule

bind region_guard rg_checker #(.NUM_REGIONS(NUM_REGIONS)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .bus_valid     (bus_valid),
  .bus_slave_err (bus_slave_err),
  .wdt_timeout   (wdt_timeout),
  .wr_block      (wr_block),
  .irq           (irq),
  .pause_req     (pause_req),
  .violation     (violation),
  .ack_wr        (ack_wr),
  .status_q      (status_q),
  .bus_err_q     (bus_err_q),
  .sealed        (sealed)
);

// File: tb/tb_region_guard.sv
module tb_region_guard;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [4:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        bus_valid = 1'b0;
  logic        bus_write = 1'b0;
  logic        bus_space = 1'b0;
  logic [23:0] bus_addr = '0;
  logic        bus_slave_err = 1'b0;
  logic        wr_block;
  logic        wdt_timeout = 1'b0;
  logic        irq;
  logic        pause_req;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  region_guard dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .bus_valid(bus_valid),
    .bus_write(bus_write), .bus_space(bus_space), .bus_addr(bus_addr),
    .bus_slave_err(bus_slave_err), .wr_block(wr_block),
    .wdt_timeout(wdt_timeout), .irq(irq), .pause_req(pause_req)
  );

  function automatic logic [23:0] win_lo(int i);
    return 24'(32'h1000 + i * 32'h100);
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  task automatic finish_sim();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  task automatic wr_reg(logic [4:0] a, logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0; reg_wdata = '0;
  endtask

  task automatic rd_reg(string req, logic [4:0] a, logic [31:0] exp);
    @(negedge clk);
    reg_addr = a;
    #1 chk(req, reg_rdata, exp);
  endtask

  task automatic bus_op(string req, logic [23:0] a, logic wr, logic sp, logic serr, logic exp_blk);
    @(negedge clk);
    bus_valid = 1'b1; bus_addr = a; bus_write = wr; bus_space = sp; bus_slave_err = serr;
    #1 chk(req, {31'b0, wr_block}, {31'b0, exp_blk});
    @(negedge clk);
    bus_valid = 1'b0; bus_write = 1'b0; bus_slave_err = 1'b0;
  endtask

  task automatic sweep(string req, logic [9:0] exp_sealed);
    for (int i = 0; i < 10; i++) begin
      bus_op(req, win_lo(i),             1'b1, 1'b0, 1'b0, exp_sealed[i]);
      bus_op(req, win_lo(i) + 24'h3F,    1'b1, 1'b0, 1'b0, exp_sealed[i]);
      bus_op(req, win_lo(i) - 24'h1,     1'b1, 1'b0, 1'b0, 1'b0);
      bus_op(req, win_lo(i) + 24'h40,    1'b1, 1'b0, 1'b0, 1'b0);
      bus_op(req, win_lo(i) + 24'h10,    1'b0, 1'b0, 1'b0, 1'b0);
    end
  endtask

  task automatic ack();
    wr_reg(5'h10, 32'h1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired");
    finish_sim();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    #1 chk("R1 irq", {31'b0, irq}, 0);
    chk("R1 pause_req", {31'b0, pause_req}, 0);
    rd_reg("R1 ctrl", 5'h10, 0);
    rd_reg("R1 buserr", 5'h11, 0);
    rd_reg("R1 memerr", 5'h12, 0);
    sweep("R1 open", 10'b0);

    // R2 single half key on register 0
    wr_reg(5'h00, 32'h0000_5555);
    bus_op("R2 armed not sealed", win_lo(0), 1'b1, 1'b0, 1'b0, 1'b0);
    wr_reg(5'h00, 32'h0000_AAAA);
    sweep("R2 window0", 10'b00_0000_0001);

    // R3 abandon on window 1
    wr_reg(5'h00, 32'h5555_0000);
    wr_reg(5'h00, 32'h1234_0000);
    wr_reg(5'h00, 32'hAAAA_0000);
    bus_op("R3 abandoned", win_lo(1), 1'b1, 1'b0, 1'b0, 1'b0);

    // R5 interleaved writes elsewhere
    wr_reg(5'h00, 32'h5555_0000);
    wr_reg(5'h10, 32'h0);
    wr_reg(5'h02, 32'h0);
    wr_reg(5'h11, 32'hFFFF_FFFF);
    bus_op("R5 still armed only", win_lo(1), 1'b1, 1'b0, 1'b0, 1'b0);
    wr_reg(5'h00, 32'hAAAA_0000);
    bus_op("R5 sealed after commit", win_lo(1), 1'b1, 1'b0, 1'b0, 1'b1);

    // R4 both halves of register 2 (windows 4,5)
    wr_reg(5'h04, 32'h5555_5555);
    wr_reg(5'h04, 32'hAAAA_AAAA);
    sweep("R4 pair", 10'b00_0011_0011);

    // R11 re-keying a sealed window does not unseal; ack keeps seal
    wr_reg(5'h00, 32'h1111_5555);
    wr_reg(5'h00, 32'h0000_0000);
    ack();
    bus_op("R11 sticky w0", win_lo(0), 1'b1, 1'b0, 1'b0, 1'b1);
    bus_op("R11 sticky w1", win_lo(1), 1'b1, 1'b0, 1'b0, 1'b1);

    // R6 seal the rest, full sweep
    wr_reg(5'h02, 32'h5555_5555);
    wr_reg(5'h02, 32'hAAAA_AAAA);
    wr_reg(5'h06, 32'h5555_5555);
    wr_reg(5'h06, 32'hAAAA_AAAA);
    wr_reg(5'h08, 32'h5555_5555);
    wr_reg(5'h08, 32'hAAAA_AAAA);
    sweep("R6 all", 10'h3FF);

    // R7/R8/R9 fault capture
    ack();
    #1 chk("R9 irq after ack", {31'b0, irq}, 0);
    rd_reg("R9 ctrl cleared", 5'h10, 0);
    bus_op("R6 blocked", 24'h1010, 1'b1, 1'b0, 1'b0, 1'b1);
    #1 chk("R9 irq set", {31'b0, irq}, 1);
    rd_reg("R7 lock flag", 5'h10, 32'h0000_8000);
    rd_reg("R8 buserr data", 5'h11, 32'h0000_1010);
    rd_reg("R8 memerr data", 5'h12, 32'h0000_1010);
    bus_op("R7 slave read", 24'h07ABCD, 1'b0, 1'b1, 1'b1, 1'b0);
    rd_reg("R7 both flags", 5'h10, 32'h0000_C000);
    rd_reg("R8 first held buserr", 5'h11, 32'h0000_1010);
    rd_reg("R8 first held memerr", 5'h12, 32'h0000_1010);
    ack();
    #1 chk("R9 irq cleared", {31'b0, irq}, 0);
    rd_reg("R9 buserr cleared", 5'h11, 0);
    rd_reg("R9 memerr cleared", 5'h12, 0);
    bus_op("R7 slave prog", 24'h07ABCD, 1'b0, 1'b1, 1'b1, 1'b0);
    rd_reg("R7 slave flag", 5'h10, 32'h0000_4000);
    rd_reg("R8 buserr prog", 5'h11, 32'h0007_ABCD);
    rd_reg("R8 memerr prog", 5'h12, 32'h2BCD_0000);
    ack();
    @(negedge clk); wdt_timeout = 1'b1;
    @(negedge clk); wdt_timeout = 1'b0;
    #1 chk("R9 irq on wdt", {31'b0, irq}, 1);
    rd_reg("R7 wdt flag", 5'h10, 32'h0000_2000);
    rd_reg("R8 wdt no capture", 5'h11, 0);

    // R10 pause enable
    chk("R10 no pause when disabled", {31'b0, pause_req}, 0);
    wr_reg(5'h10, 32'h2);
    #1 chk("R10 pause with pending", {31'b0, pause_req}, 1);
    rd_reg("R10 enable readback", 5'h10, 32'h0000_2002);
    wr_reg(5'h10, 32'h3);
    #1 chk("R10 pause dropped on ack", {31'b0, pause_req}, 0);
    rd_reg("R10 enable kept", 5'h10, 32'h0000_0002);
    bus_op("R10 slave", 24'h000100, 1'b1, 1'b0, 1'b1, 1'b0);
    #1 chk("R10 pause on fault", {31'b0, pause_req}, 1);
    wr_reg(5'h10, 32'h0);
    #1 chk("R10 pause off, irq stays", {31'b0, pause_req, irq}, 32'h1);
    ack();
    #1 chk("R9 final irq", {31'b0, irq}, 0);

    finish_sim();
  end
endmodule